// File: doc/BRIEF.md
# Filtered Pin Edge Interrupt Unit

This block conditions a port of input pins and turns selected transitions on them into sticky interrupt flags and single-cycle event pulses. Every pin first passes through a two-flop synchroniser. An optional per-pin glitch filter follows it and passes a level only after that level has been seen on two consecutive samples. The conditioned level then feeds an edge detector whose sensitivity is set by two mode bits per pin.

A detected edge produces a one-cycle pulse on the pin's event output, which other logic may use as a trigger. The same edge sets the pin's flag. The flag holds until software writes a one to that pin's bit through the flag-clear select. The single interrupt output is raised whenever any pin has both its flag and its enable set.

Configuration is done one word per cycle. A write strobe carries a select code and a data word, and each one bit in the data word acts on the matching pin. Enable, mode bit 0, mode bit 1 and filter enable each have their own set select and clear select.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, every flag, every event output and the interrupt output are 0, and all enables, mode bits and filter enables are 0.
- R2: With the filter bypassed, a pin change set up before clock edge E0 gives an event pulse in the cycle after edge E1 and a set flag after edge E2. Enabling the filter moves both two cycles later.
- R3: Mode {m1,m0} = 00 detects both rising and falling edges of the conditioned level.
- R4: Mode 01 detects rising edges only.
- R5: Mode 10 detects falling edges only. Mode 11 detects no edges.
- R6: With the filter enabled, a pin pulse lasting one clock cycle produces no edge. A pulse of two or more cycles produces both of its edges.
- R7: A flag stays set until a flag-clear write with a one in that pin's bit. The clear takes effect whether or not the pin's interrupt is enabled. Zero bits in the clear word leave their flags unchanged.
- R8: If a flag-clear write and a new detected edge on the same pin fall in the same cycle, the flag remains set.
- R9: irqOut is the OR over all pins of (flag AND enable). A pin with its enable clear still sets its flag but does not raise irqOut.
- R10: An enable-set write also turns on that pin's filter. An enable-clear write leaves the filter setting unchanged.
- R11: eventOut pulses high for exactly one cycle per detected edge, independent of the pin's enable.
- R12: The select codes are: 0 enable set, 1 enable clear, 2 mode0 set, 3 mode0 clear, 4 mode1 set, 5 mode1 clear, 6 filter set, 7 filter clear, 8 flag clear. Codes 9 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw pin levels, may be asynchronous |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | 4 | Write select code (see R12) |
| wrData | input | NUM_PINS | Per-pin write mask, one bit per pin |
| flagOut | output | NUM_PINS | Sticky interrupt flags |
| eventOut | output | NUM_PINS | One-cycle detected-edge pulses |
| irqOut | output | 1 | Port interrupt request |

## Verification
A wrong mode decode or filter state shows up in the number of event pulses counted within about a dozen cycles of a shaped pulse. The sweep therefore compares that count, for every pin, mode, filter setting, start level and pulse width, against a count derived from the edges the pulse contains. A broken sampler or a missing synchroniser stage moves the first event or flag cycle away from its fixed position, so each of those is sampled at one exact cycle. A bad flag priority or clear decode appears on flagOut at the cycle right after the contested edge, and a broken enable gate appears on irqOut in that same cycle.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;

  typedef enum logic [3:0] {
    SEL_ENA_SET   = 4'd0,
    SEL_ENA_CLR   = 4'd1,
    SEL_MODE0_SET = 4'd2,
    SEL_MODE0_CLR = 4'd3,
    SEL_MODE1_SET = 4'd4,
    SEL_MODE1_CLR = 4'd5,
    SEL_FILT_SET  = 4'd6,
    SEL_FILT_CLR  = 4'd7,
    SEL_FLAG_CLR  = 4'd8
  } cfgSel_e;

  typedef struct packed {
    logic enaSet;
    logic enaClr;
    logic m0Set;
    logic m0Clr;
    logic m1Set;
    logic m1Clr;
    logic filtSet;
    logic filtClr;
    logic flagClr;
  } cfgStrobe_t;

  localparam logic [1:0] MODE_ANY  = 2'b00;
  localparam logic [1:0] MODE_RISE = 2'b01;
  localparam logic [1:0] MODE_FALL = 2'b10;

endpackage

// File: rtl/pin_edge_irq_ctrl.sv
module pin_edge_irq_ctrl
  import pin_edge_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [3:0] wrSel,
  output cfgStrobe_t stb
);

  // One strobe per select code; unknown codes decode to nothing (R12)
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_ENA_SET:   stb.enaSet  = 1'b1;
        SEL_ENA_CLR:   stb.enaClr  = 1'b1;
        SEL_MODE0_SET: stb.m0Set   = 1'b1;
        SEL_MODE0_CLR: stb.m0Clr   = 1'b1;
        SEL_MODE1_SET: stb.m1Set   = 1'b1;
        SEL_MODE1_CLR: stb.m1Clr   = 1'b1;
        SEL_FILT_SET:  stb.filtSet = 1'b1;
        SEL_FILT_CLR:  stb.filtClr = 1'b1;
        SEL_FLAG_CLR:  stb.flagClr = 1'b1;
        default:       stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/pin_edge_irq_cell.sv
module pin_edge_irq_cell
  import pin_edge_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       wrBit,
  input  cfgStrobe_t stb,
  output logic       flagQ,
  output logic       evtOut,
  output logic       enaQ
);

  logic syncA, syncB;
  logic sampQ, filtQ;
  logic prevQ;
  logic mode0Q, mode1Q, fltEnQ;
  logic cond, rise, fall, hit;

  // Conditioned level: filtered or straight from the synchroniser
  assign cond = fltEnQ ? filtQ : syncB;
  assign rise = cond & ~prevQ;
  assign fall = ~cond & prevQ;

  always_comb begin
    case ({mode1Q, mode0Q})
      MODE_ANY:  hit = rise | fall;
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      default:   hit = 1'b0;
    endcase
  end

  assign evtOut = hit;

  // Synchroniser, two-sample agreement filter and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      sampQ <= 1'b0;
      filtQ <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      sampQ <= syncB;
      if (sampQ == syncB) filtQ <= syncB;
      prevQ <= cond;
    end
  end

  // Configuration bits with set/clear aliases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enaQ   <= 1'b0;
      mode0Q <= 1'b0;
      mode1Q <= 1'b0;
      fltEnQ <= 1'b0;
    end else if (wrBit) begin
      if (stb.enaSet)      enaQ <= 1'b1;
      else if (stb.enaClr) enaQ <= 1'b0;
      if (stb.m0Set)       mode0Q <= 1'b1;
      else if (stb.m0Clr)  mode0Q <= 1'b0;
      if (stb.m1Set)       mode1Q <= 1'b1;
      else if (stb.m1Clr)  mode1Q <= 1'b0;
      if (stb.filtSet || stb.enaSet) fltEnQ <= 1'b1;
      else if (stb.filtClr)          fltEnQ <= 1'b0;
    end
  end

  // Sticky flag: a new edge wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         flagQ <= 1'b0;
    else if (hit)                      flagQ <= 1'b1;
    else if (stb.flagClr && wrBit)     flagQ <= 1'b0;
  end

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(stb.flagClr && wrBit)) |=> flagQ);

  p_clear_works_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagClr && wrBit && !hit) |=> !flagQ);

  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> flagQ);

  p_ena_filt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enaSet && wrBit) |=> (enaQ && fltEnQ));

  p_filter_agree_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtQ) |-> (filtQ == $past(syncB) && filtQ == $past(syncB, 2)));

  p_one_cycle_event_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(hit)) |-> ({mode1Q, mode0Q} == MODE_ANY));

endmodule

// File: rtl/pin_edge_irq_dp.sv
module pin_edge_irq_dp
  import pin_edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] wrData,
  input  cfgStrobe_t          stb,
  output logic [NUM_PINS-1:0] flagOut,
  output logic [NUM_PINS-1:0] eventOut,
  output logic                irqOut
);

  localparam int LastPin = NUM_PINS - 1;

  logic [LastPin:0] enaVec;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    pin_edge_irq_cell u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinIn[gi]),
      .wrBit  (wrData[gi]),
      .stb    (stb),
      .flagQ  (flagOut[gi]),
      .evtOut (eventOut[gi]),
      .enaQ   (enaVec[gi])
    );
  end

  assign irqOut = |(flagOut & enaVec);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (flagOut != '0));

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [3:0]          wrSel,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] flagOut,
  output logic [NUM_PINS-1:0] eventOut,
  output logic                irqOut
);

  cfgStrobe_t stb;

  pin_edge_irq_ctrl u_ctrl (
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .stb   (stb)
  );

  pin_edge_irq_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .wrData   (wrData),
    .stb      (stb),
    .flagOut  (flagOut),
    .eventOut (eventOut),
    .irqOut   (irqOut)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (flagOut == '0));

endmodule

// File: tb/pin_edge_irq_tb.sv
module pin_edge_irq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          wrEn = 1'b0;
  logic [3:0]    wrSel = '0;
  logic [NP-1:0] wrData = '0;
  logic [NP-1:0] flagOut, eventOut;
  logic          irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_edge_irq #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .flagOut(flagOut), .eventOut(eventOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called just after a negedge; the write lands on the next posedge
  task automatic doWrite(input int sel, input logic [NP-1:0] data);
    wrEn = 1'b1; wrSel = 4'(sel); wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int detects(input int mode, input bit rising);
    case (mode)
      0: return 1;
      1: return rising ? 1 : 0;
      2: return rising ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  task automatic setup(input int p, input int mode, input bit filt, input bit lvl);
    logic [NP-1:0] m;
    m = NP'(1) << p;
    pinIn[p] = lvl;
    idle(8);
    doWrite(0, m);
    doWrite(filt ? 6 : 7, m);
    doWrite(mode[0] ? 2 : 3, m);
    doWrite(mode[1] ? 4 : 5, m);
    idle(4);
    doWrite(8, ALL);
  endtask

  task automatic runCase(input int p, input int mode, input bit filt, input bit lvl, input int w);
    int cnt, exp;
    string tag;
    setup(p, mode, filt, lvl);
    cnt = 0;
    for (int c = 0; c < w + 10; c++) begin
      pinIn[p] = (c < w) ? ~lvl : lvl;
      @(negedge clk);
      cnt += eventOut[p];
    end
    exp = (filt && w == 1) ? 0 : detects(mode, lvl == 1'b0) + detects(mode, lvl == 1'b1);
    if (filt && w == 1) tag = "R6 short pulse rejected";
    else if (filt && w == 2) tag = "R6 two-cycle pulse kept";
    else if (mode == 0) tag = "R3 any-change count";
    else if (mode == 1) tag = "R4 rising count";
    else tag = "R5 falling/none count";
    chk($sformatf("%s p%0d m%0d f%0d l%0d w%0d", tag, p, mode, filt, lvl, w), cnt, exp);
    chk($sformatf("R7 flag after pulse p%0d m%0d", p, mode), flagOut[p], exp > 0);
    chk($sformatf("R9 irq equals enabled flag p%0d", p), irqOut, exp > 0);
  endtask

  task automatic latency(input bit filt);
    int firstEvt, firstFlag;
    setup(0, 0, filt, 1'b0);
    firstEvt = -1; firstFlag = -1;
    pinIn[0] = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (eventOut[0] && firstEvt < 0) firstEvt = j;
      if (flagOut[0] && firstFlag < 0) firstFlag = j;
    end
    chk($sformatf("R2 event cycle filt=%0d", filt), firstEvt, filt ? 3 : 1);
    chk($sformatf("R2 flag cycle filt=%0d", filt), firstFlag, filt ? 4 : 2);
    chk("R11 single event pulse", eventOut[0], 0);
    pinIn[0] = 1'b0;
    idle(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 flags at reset", flagOut, 0);
    chk("R1 events at reset", eventOut, 0);
    chk("R1 irq at reset", irqOut, 0);
    rstN = 1'b1;
    idle(3);
    chk("R1 flags after release", flagOut, 0);

    latency(1'b0);
    latency(1'b1);

    for (int p = 0; p < NP; p++)
      for (int mode = 0; mode < 4; mode++)
        for (int f = 0; f < 2; f++)
          for (int l = 0; l < 2; l++)
            for (int w = 1; w <= 3; w++)
              runCase(p, mode, f[0], l[0], w);

    // R8: clear lands on the same edge as a new detected edge
    setup(1, 0, 1'b0, 1'b0);
    pinIn[1] = 1'b1;
    idle(2);
    chk("R11 event visible before contested clear", eventOut[1], 1);
    doWrite(8, ALL);
    chk("R8 edge beats same-cycle clear", flagOut[1], 1);
    idle(3);
    doWrite(8, 4'b0000);
    chk("R7 zero clear mask keeps flag", flagOut[1], 1);
    doWrite(15, ALL);
    chk("R12 unused select code ignored", flagOut[1], 1);
    doWrite(8, ALL);
    chk("R7 clear while enabled", flagOut[1], 0);

    // R10 / R9: enable clear keeps filter, disabled pin still flags
    setup(2, 0, 1'b0, 1'b0);
    doWrite(0, 4'b0100);
    doWrite(1, 4'b0100);
    idle(2);
    pinIn[2] = 1'b1;
    @(negedge clk);
    pinIn[2] = 1'b0;
    idle(10);
    chk("R10 enable set turned filter on (1-cycle pulse gone)", flagOut[2], 0);
    pinIn[2] = 1'b1;
    idle(2);
    pinIn[2] = 1'b0;
    idle(10);
    chk("R9 disabled pin still flags", flagOut[2], 1);
    chk("R9 disabled pin gives no irq", irqOut, 0);
    doWrite(0, 4'b0100);
    chk("R9 enable raises irq from held flag", irqOut, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule